// File: doc/BRIEF.md
# Serial Address Loader with Post-Increment

This block keeps a 16-bit write pointer that comes out of reset at zero. Each accepted request loads that pointer into a shift register and sends it bit by bit, on a data line and a shift clock of its own, into two cascaded 8-bit serial-in/parallel-out registers outside the chip. Once all bits are out, the block raises a one-cycle completion strobe and adds one to the pointer. The next request therefore presents the next location without any further work from the requester.

The upper byte goes out first and the lower byte second, each byte starting at its most significant bit. When the clocking stops, the downstream register of the chain holds the upper byte and the upstream register holds the lower byte, with the most significant bit of each on its last stage. The shift clock runs at a programmable fraction of the system clock. The data line only moves while the shift clock is low, so each bit is steady for a full low phase before the rising edge that captures it.

Top module: `sal_loader`

## Requirements
- R1: After reset, sclk_o, sdata_o and done_o are low, and the first load presents address 0x0000.
- R2: Each load produces exactly 16 rising edges on sclk_o, and sclk_o is low whenever no load is in progress.
- R3: After a load, the register fed by the upstream register's bit 7 holds address bits 15:8, and the register fed by sdata_o holds bits 7:0. In each register, bit 7 holds the most significant bit of its byte.
- R4: sdata_o changes only while sclk_o is low. It has the same value in the cycle before each sclk_o rising edge and throughout the following high phase.
- R5: Every high phase of sclk_o lasts exactly CLK_DIV system clock cycles. Every low phase between two rising edges also lasts exactly CLK_DIV cycles.
- R6: done_o is high for exactly one cycle per load. Counting the edge that samples start_i as the first, done_o first reads high after edge 32*CLK_DIV+1.
- R7: After each load the address increases by one. A carry out of the low byte (0x00FF to 0x0100) increments the high byte.
- R8: start_i is ignored from the cycle after a request is accepted until done_o has fallen. Such a start_i neither restarts the transfer nor changes the address that the next load presents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to send the current address; sampled only while idle |
| sdata_o | output | 1 | Serial address data, most significant bit first |
| sclk_o | output | 1 | Shift clock for the external register chain; idles low |
| done_o | output | 1 | One-cycle strobe when the address has been sent |

## Verification
A faulty pointer or carry appears as a wrong parallel word in the modelled register chain at the very next completion strobe. A carry fault at the low byte's rollover appears only at the load that follows 0x00FF, so the run must go past that point. A miscounted bit index or divider appears at the same strobe, as a rising-edge count other than 16 or a shifted word. A sequencer that reacts to a stray request shows up as a skipped address one load later. A data line that moves while the clock is high is caught at the very next shift-clock phase.

// File: rtl/sal_pkg.sv
package sal_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

endpackage

// File: rtl/sal_addr_ctr.sv
module sal_addr_ctr #(
    parameter int ADDR_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int NUM_LANES = ADDR_W / BYTE_W;

    logic [ADDR_W-1:0]  addr_d, addr_q;
    logic [NUM_LANES:0] carry;

    // byte-wise post-increment with a ripple carry between lanes
    always_comb begin
        carry[0] = inc_i;
        addr_d   = addr_q;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (carry[i]) begin
                addr_d[i*BYTE_W +: BYTE_W] = addr_q[i*BYTE_W +: BYTE_W] + 1'b1;
            end
            carry[i+1] = carry[i] & (&addr_q[i*BYTE_W +: BYTE_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;

    // R7: one load adds exactly one to the pointer
    a_r7_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> addr_q == $past(addr_q) + 1'b1);

    // R8: without an increment request the pointer is frozen
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(addr_q));

    // R7: an upper lane moves only when every lane below it wraps
    for (genvar g = 1; g < NUM_LANES; g++) begin : g_lane_chk
        a_r7_lane_carry: assert property (@(posedge clk) disable iff (!rst_n)
            (inc_i && !(&addr_q[g*BYTE_W-1:0])) |=>
                $stable(addr_q[g*BYTE_W +: BYTE_W]));
    end

endmodule

// File: rtl/sal_shifter.sv
module sal_shifter #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              sdata_o
);
    logic [ADDR_W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d = addr_i;
        end else if (shift_i) begin
            sh_d = {sh_q[ADDR_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sdata_o = sh_q[ADDR_W-1];

    // R3: a load places the requested word in the shift register
    a_r3_load_word: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> sh_q == $past(addr_i));

endmodule

// File: rtl/sal_seq.sv
module sal_seq
    import sal_pkg::*;
#(
    parameter int CLK_DIV    = 2,
    parameter int TOTAL_BITS = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start_i,
    output phase_e phase_o,
    output logic   load_o,
    output logic   shift_o,
    output logic   inc_o
);
    localparam int CNT_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = (TOTAL_BITS > 1) ? $clog2(TOTAL_BITS) : 1;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] div;
        logic [BIT_W-1:0] bits;
    } seq_t;

    seq_t seq_d, seq_q;
    logic div_end, last_bit;

    assign div_end  = (seq_q.div == CNT_W'(CLK_DIV - 1));
    assign last_bit = (seq_q.bits == BIT_W'(TOTAL_BITS - 1));

    always_comb begin
        seq_d   = seq_q;
        load_o  = 1'b0;
        shift_o = 1'b0;
        unique case (seq_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.phase = PH_LOW;
                    seq_d.div   = '0;
                    seq_d.bits  = '0;
                    load_o      = 1'b1;
                end
            end
            PH_LOW: begin
                if (div_end) begin
                    seq_d.phase = PH_HIGH;
                    seq_d.div   = '0;
                end else begin
                    seq_d.div = seq_q.div + 1'b1;
                end
            end
            PH_HIGH: begin
                if (div_end) begin
                    seq_d.div = '0;
                    if (last_bit) begin
                        seq_d.phase = PH_DONE;
                    end else begin
                        seq_d.phase = PH_LOW;
                        seq_d.bits  = seq_q.bits + 1'b1;
                        shift_o     = 1'b1;
                    end
                end else begin
                    seq_d.div = seq_q.div + 1'b1;
                end
            end
            PH_DONE: begin
                seq_d.phase = PH_IDLE;
            end
            default: begin
                seq_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{phase: PH_IDLE, div: '0, bits: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o = seq_q.phase;
    assign inc_o   = (seq_q.phase == PH_DONE);

    // R6: the completion phase lasts one cycle and returns to idle
    a_r6_done_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.phase == PH_DONE |=> seq_q.phase == PH_IDLE);

    // R8: a request during a transfer does not rewind the bit index
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.phase == PH_LOW && start_i && seq_q.bits != '0) |=>
            seq_q.bits != '0);

endmodule

// File: rtl/sal_loader.sv
module sal_loader
    import sal_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BYTE_W  = 8,
    parameter int CLK_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic sdata_o,
    output logic sclk_o,
    output logic done_o
);
    localparam int TOTAL_BITS = ADDR_W;
    localparam int RISE_W     = $clog2(TOTAL_BITS + 1) + 1;

    phase_e            phase_w;
    logic              load_w, shift_w, inc_w;
    logic [ADDR_W-1:0] addr_w;

    sal_seq #(
        .CLK_DIV    (CLK_DIV),
        .TOTAL_BITS (TOTAL_BITS)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .phase_o (phase_w),
        .load_o  (load_w),
        .shift_o (shift_w),
        .inc_o   (inc_w)
    );

    sal_shifter #(
        .ADDR_W (ADDR_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_w),
        .shift_i (shift_w),
        .addr_i  (addr_w),
        .sdata_o (sdata_o)
    );

    sal_addr_ctr #(
        .ADDR_W (ADDR_W),
        .BYTE_W (BYTE_W)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc_i  (inc_w),
        .addr_o (addr_w)
    );

    assign sclk_o = (phase_w == PH_HIGH);
    assign done_o = inc_w;

    // checker state: rising edges of the shift clock since the last load
    logic              sclk_prev_q;
    logic [RISE_W-1:0] rise_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            rise_q      <= '0;
        end else begin
            sclk_prev_q <= sclk_o;
            if (load_w) begin
                rise_q <= '0;
            end else if (sclk_o && !sclk_prev_q) begin
                rise_q <= rise_q + 1'b1;
            end
        end
    end

    // R2: every completion follows exactly TOTAL_BITS clock pulses
    a_r2_pulse_count: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> rise_q == RISE_W'(TOTAL_BITS));

    // R4: data holds still while the shift clock is high
    a_r4_data_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> $stable(sdata_o));

    // R6: the strobe never lasts two cycles
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2: a new transfer starts with the shift clock low
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        load_w |=> !sclk_o);

endmodule

// File: tb/sim_sal_loader.sv
module sim_sal_loader;

    localparam int ADDR_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int CLK_DIV = 2;
    localparam int N_LOADS = 262;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic sdata_o, sclk_o, done_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sal_loader #(
        .ADDR_W  (ADDR_W),
        .BYTE_W  (BYTE_W),
        .CLK_DIV (CLK_DIV)
    ) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .sdata_o (sdata_o),
        .sclk_o  (sclk_o),
        .done_o  (done_o)
    );

    // model of the two cascaded 8-bit serial-in/parallel-out registers
    logic [7:0] chain_up = '0;
    logic [7:0] chain_dn = '0;
    int         rise_total = 0;
    logic       neg_sdata = 1'b0;
    logic       rise_bit = 1'b0;
    int         setup_bad = 0;

    always @(posedge sclk_o) begin
        chain_up   <= {chain_up[6:0], sdata_o};
        chain_dn   <= {chain_dn[6:0], chain_up[7]};
        rise_total <= rise_total + 1;
        rise_bit   <= sdata_o;
        if (sdata_o !== neg_sdata) setup_bad <= setup_bad + 1;
    end

    // phase-width and hold monitor, sampled away from the active edge
    int   hi_run = 0;
    int   lo_run = 0;
    bit   lo_armed = 1'b0;
    int   width_bad = 0;
    int   hold_bad = 0;

    always @(negedge clk) begin
        neg_sdata = sdata_o;
        if (sclk_o) begin
            if (lo_armed && lo_run != CLK_DIV) width_bad++;
            lo_armed = 1'b0;
            lo_run   = 0;
            hi_run++;
            if (sdata_o !== rise_bit) hold_bad++;
        end else begin
            if (hi_run > 0) begin
                if (hi_run != CLK_DIV) width_bad++;
                hi_run   = 0;
                lo_armed = 1'b1;
            end
            if (done_o) begin
                lo_armed = 1'b0;
                lo_run   = 0;
            end else if (lo_armed) begin
                lo_run++;
            end
        end
    end

    function automatic int exp_latency(input int div);
        return 2 * ADDR_W * div + 1;
    endfunction

    function automatic logic [15:0] exp_chain(input logic [ADDR_W-1:0] a);
        return {a[15:8], a[7:0]};
    endfunction

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic [ADDR_W-1:0] exp_addr = '0;

    // inj: 0 = no stray requests, 1 = random, 2 = every cycle
    task automatic do_load(input int inj);
        int lat;
        int base;
        base = rise_total;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        while (!done_o && lat < 1000) begin
            start_i = (inj == 2) || (inj == 1 && ($urandom % 6 == 0));
            @(negedge clk);
            lat++;
        end
        check(lat == exp_latency(CLK_DIV), "R6 latency", lat, exp_latency(CLK_DIV));
        check(rise_total - base == ADDR_W, "R2 pulse count", rise_total - base, ADDR_W);
        check({chain_dn, chain_up} == exp_chain(exp_addr), "R3 R7 chain word",
              {chain_dn, chain_up}, exp_chain(exp_addr));
        start_i = (inj != 0);
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b0, "R6 strobe width", done_o, 0);
        check(sclk_o == 1'b0, "R2 idle clock low", sclk_o, 0);
        exp_addr = exp_addr + 1'b1;
    endtask

    initial begin
        void'($urandom(32'h1357));
        repeat (3) @(negedge clk);
        check(sclk_o == 1'b0, "R1 reset sclk", sclk_o, 0);
        check(done_o == 1'b0, "R1 reset done", done_o, 0);
        check(sdata_o == 1'b0, "R1 reset sdata", sdata_o, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(sclk_o == 1'b0 && done_o == 1'b0, "R1 idle after reset",
              {sclk_o, done_o}, 0);

        // R1: first load must carry 0x0000
        do_load(0);
        // R8: directed flood of stray requests
        do_load(2);
        do_load(2);

        for (int i = 3; i < N_LOADS; i++) begin
            int gap;
            int mode;
            mode = (i == 255 || i == 256) ? 2 : int'($urandom % 2);
            do_load(mode);
            gap = int'($urandom % 4);
            repeat (gap) @(negedge clk);
        end

        // R7: the run crossed the low-byte carry into the high byte
        check(exp_addr == ADDR_W'(N_LOADS), "R7 carry reached", exp_addr, N_LOADS);
        check(setup_bad == 0, "R4 data before rise", setup_bad, 0);
        check(hold_bad == 0, "R4 data held high", hold_bad, 0);
        check(width_bad == 0, "R5 phase widths", width_bad, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule